// File: doc/BRIEF.md
# SSB Receive Demodulator Datapath

This block turns a single time-multiplexed ADC stream into an audio code for a PWM DAC. The stream carries the quadrature (Q) and in-phase (I) channels of a direct-conversion receiver, with the two channels taking turns. Each channel therefore runs at half the strobe rate.

Each channel has its own 15-entry delay line. I is sampled half a channel period after Q, so each stored I value is the mean of the newest and the previous raw I sample. That pulls I back into line with Q. On every I sample, the block passes the Q line through a 15-tap antisymmetric Hilbert filter. Only the even taps are non-zero. It subtracts the result from the centre I entry, which selects one sideband. The difference is scaled down, offset to the middle of a 250-count PWM range, clamped, and presented with a one-cycle valid pulse.

An enable input from the transmit side freezes the block. While it is high, strobes are discarded and no internal state moves.

Top module: `ssb_rx_demod`

## Requirements
- R1: After reset the first accepted strobe is a Q sample, and accepted strobes then alternate strictly Q, I, Q, I. A Q strobe never produces an output.
- R2: A raw 12-bit unsigned sample becomes signed by subtracting 2048.
- R3: On a Q strobe the Q line shifts one place towards the oldest entry (index 0), and the new signed sample enters at index 14.
- R4: On an I strobe the value entering I index 14 is (current + previous signed I) / 2, truncated toward zero. The current sample then becomes the previous one.
- R5: Hilbert value h = ((q0-q14)*315 + (q2-q12)*440 + (q4-q10)*734 + (q6-q8)*2202) / 4096, truncated toward zero, where q0 is the oldest Q entry. It is formed from a sum at least 32 bits wide.
- R6: On each I strobe, d = (i7 - h) / 32, truncated toward zero. Here i7 is the I centre entry after this strobe's shift, which is the value stored seven I strobes earlier.
- R7: The cycle after each accepted I strobe, aud_valid is high for exactly one cycle and aud_code = 125 + d. At all other times aud_code holds its value.
- R8: aud_code saturates to the range 0..250.
- R9: A strobe taken while tx_en is high has no effect. It produces no output and moves neither the phase, the delay lines nor the previous-I value.
- R10: Reset clears both delay lines, the previous-I value and the phase, sets aud_code to 125 and clears aud_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | One-cycle strobe marking a new ADC sample |
| smp_data | input | 12 | Raw unsigned ADC sample |
| tx_en | input | 1 | High while transmitting; strobes are discarded |
| aud_valid | output | 1 | One-cycle pulse when aud_code is updated |
| aud_code | output | 8 | Unsigned PWM duty code, 0..250 |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 250-count DAC range, a divisor of 32 and a Hilbert divisor of 4096. With these values a full-scale Q impulse walks through every tap of the filter, and each tap gives a distinct output code, so the tap weights, their signs and the truncation toward zero can all be checked. The same full-scale range also lets a Q step against a full-scale I value push the result past both ends of the code range, which reaches the clamps.

// File: rtl/ssb_rx_demod.sv
module ssb_rx_demod #(
  parameter int SMP_W     = 12,
  parameter int DAC_RANGE = 250,
  parameter int OUT_W     = 8,
  parameter int OUT_DIV   = 32,
  parameter int HILB_DIV  = 4096,
  parameter int ACC_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             tx_en,
  output logic             aud_valid,
  output logic [OUT_W-1:0] aud_code
);
  localparam int TAPS    = 15;
  localparam int MID     = TAPS / 2;
  localparam int DAC_MID = DAC_RANGE / 2;
  localparam int NCOEF   = 4;
  localparam int COEF [NCOEF] = '{315, 440, 734, 2202};
  localparam logic signed [ACC_W-1:0] TWO_D  = ACC_W'(2);
  localparam logic signed [ACC_W-1:0] HILB_D = ACC_W'(HILB_DIV);
  localparam logic signed [ACC_W-1:0] OUT_D  = ACC_W'(OUT_DIV);
  localparam logic signed [ACC_W-1:0] MID_D  = ACC_W'(DAC_MID);
  localparam logic signed [ACC_W-1:0] TOP_D  = ACC_W'(DAC_RANGE);

  logic signed [SMP_W-1:0] q_line [TAPS];
  logic signed [SMP_W-1:0] i_line [TAPS];
  logic signed [SMP_W-1:0] i_prev;
  logic                    phase;

  logic                    take;
  logic signed [SMP_W-1:0] s_in;
  logic signed [ACC_W-1:0] i_avg, acc, hilb, diff, demod, code_full;
  logic        [OUT_W-1:0] code_next;

  assign take = smp_valid && !tx_en;
  assign s_in = $signed({~smp_data[SMP_W-1], smp_data[SMP_W-2:0]});
  assign i_avg = (ACC_W'(s_in) + ACC_W'(i_prev)) / TWO_D;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NCOEF; k++)
      acc += (ACC_W'(q_line[2*k]) - ACC_W'(q_line[TAPS-1-2*k])) * ACC_W'(COEF[k]);
  end

  assign hilb      = acc / HILB_D;
  assign diff      = ACC_W'(i_line[MID+1]) - hilb;
  assign demod     = diff / OUT_D;
  assign code_full = demod + MID_D;

  always_comb begin
    if (code_full < 0)          code_next = '0;
    else if (code_full > TOP_D) code_next = OUT_W'(DAC_RANGE);
    else                        code_next = OUT_W'(code_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        q_line[k] <= '0;
        i_line[k] <= '0;
      end
      i_prev    <= '0;
      phase     <= 1'b0;
      aud_valid <= 1'b0;
      aud_code  <= OUT_W'(DAC_MID);
    end else begin
      aud_valid <= 1'b0;
      if (take) begin
        phase <= ~phase;
        if (!phase) begin
          for (int k = 0; k < TAPS-1; k++) q_line[k] <= q_line[k+1];
          q_line[TAPS-1] <= s_in;
        end else begin
          for (int k = 0; k < TAPS-1; k++) i_line[k] <= i_line[k+1];
          i_line[TAPS-1] <= SMP_W'(i_avg);
          i_prev    <= s_in;
          aud_valid <= 1'b1;
          aud_code  <= code_next;
        end
      end
    end
  end

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> phase != $past(phase)); // R1

  AST_Q_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !phase) |=> !aud_valid); // R1

  AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid |-> $past(take)); // R7

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(aud_code)); // R7

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    aud_code <= OUT_W'(DAC_RANGE)); // R8

  AST_TX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && tx_en) |=> $stable(phase) && $stable(i_prev) && !aud_valid); // R9
endmodule

// File: tb/test_ssb_rx_demod.sv
`timescale 1ns/1ps
module test_ssb_rx_demod;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        tx_en = 1'b0;
  logic        aud_valid;
  logic [7:0]  aud_code;

  int n_chk = 0;
  int n_bad = 0;
  int got_v, got_c;

  always #2 clk = ~clk;

  ssb_rx_demod i_ssb_rx_demod (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .tx_en(tx_en), .aud_valid(aud_valid), .aud_code(aud_code)
  );

  // Q impulse of +2047 followed by zeros, I held at zero: one row per Q/I pair
  localparam int NVEC = 16;
  localparam int TAB_Q   [NVEC] = '{4095, 2048, 2048, 2048, 2048, 2048, 2048, 2048,
                                    2048, 2048, 2048, 2048, 2048, 2048, 2048, 2048};
  localparam int TAB_I   [NVEC] = '{2048, 2048, 2048, 2048, 2048, 2048, 2048, 2048,
                                    2048, 2048, 2048, 2048, 2048, 2048, 2048, 2048};
  localparam int TAB_EXP [NVEC] = '{129, 125, 131, 125, 136, 125, 159, 125,
                                     91, 125, 114, 125, 119, 125, 121, 125};

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic push(input int raw, input bit tx);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 12'(raw);
    tx_en     = tx;
    @(negedge clk);
    smp_valid = 1'b0;
    tx_en     = 1'b0;
    got_v = int'(aud_valid);
    got_c = int'(aud_code);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R10 reset code", int'(aud_code), 125);
    chk("R10 reset valid", int'(aud_valid), 0);

    // R1 R2 R3 R5 R6: Hilbert tap walk, truncation toward zero on both signs
    for (int n = 0; n < NVEC; n++) begin
      push(TAB_Q[n], 1'b0);
      chk("R1 no output on Q strobe", got_v, 0);
      push(TAB_I[n], 1'b0);
      chk("R7 valid after I strobe", got_v, 1);
      chk("R5 R6 tap walk code", got_c, TAB_EXP[n]);
      if (n == 0) begin
        @(negedge clk);
        chk("R7 valid is one cycle", int'(aud_valid), 0);
        chk("R7 code holds", int'(aud_code), TAB_EXP[0]);
      end
    end

    // R4 R6 R10: negative I impulse (-1025), averaged into two entries, seen at I strobes 8 and 9
    do_reset();
    for (int n = 1; n <= 10; n++) begin
      push(2048, 1'b0);
      push((n == 1) ? 1023 : 2048, 1'b0);
      if (n == 7)  chk("R6 before I delay", got_c, 125);
      if (n == 8)  chk("R4 first average", got_c, 109);
      if (n == 9)  chk("R4 average with previous", got_c, 109);
      if (n == 10) chk("R4 impulse cleared", got_c, 125);
    end

    // R9: odd number of transmit-time strobes must not move phase or previous I
    do_reset();
    for (int n = 1; n <= 9; n++) begin
      push(2048, 1'b0);
      push((n == 1) ? 1023 : 2048, 1'b0);
      if (n == 1) begin
        push(4095, 1'b1);
        chk("R9 no output during tx", got_v, 0);
        push(0, 1'b1);
        chk("R9 no output during tx", got_v, 0);
        push(4095, 1'b1);
        chk("R9 code frozen during tx", got_c, 125);
      end
      if (n == 8) chk("R9 state untouched by tx", got_c, 109);
      if (n == 9) chk("R9 previous I untouched", got_c, 109);
    end

    // R8: Q step against full-scale I drives the code to both clamps
    do_reset();
    for (int n = 1; n <= 15; n++) begin
      push((n <= 8) ? 4095 : 0, 1'b0);
      push(0, 1'b0);
    end
    chk("R8 low clamp", got_c, 0);
    do_reset();
    for (int n = 1; n <= 15; n++) begin
      push((n <= 8) ? 0 : 4095, 1'b0);
      push(4095, 1'b0);
    end
    chk("R8 high clamp", got_c, 250);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule